// File: doc/BRIEF.md
# Dual-Issue Dispatch Stall Controller

This block sits between a two-entry dispatch window of an instruction queue and the execution units. On each clock edge it looks at the two oldest queue entries, slot 0 being the older, and decides how many of them leave the queue: none, slot 0 alone, or both. The decision is made in program order. The younger entry never overtakes the older one. An entry dispatches only when four kinds of resource allow it: its target unit (or that unit's reservation station), a destination rename register if it writes a result, a completion-queue slot, and the rule for completion-serialized instructions.

The decision is registered. Candidate information sampled at edge N produces dispatch enables, target unit codes and a queue shift amount that are valid for the whole cycle after edge N. The queue logic upstream uses the shift amount to move the remaining entries toward entry 0. Each slot's valid flag works as the valid half of a handshake, and the registered dispatch enable is its ready. A slot that is not granted stays where it is and is offered again, which is the form back-pressure takes. Unit busy flags, reservation-station flags and free counts are plain status inputs.

Unit codes are indices from 0 to NUM_UNITS-1 (default 5 units, 3-bit code). A parameter mask marks the units whose station can take a second instruction in the same cycle. By default only unit 2 is marked.

Top module: `dispatch_stall_ctrl`

## Requirements
- R1: While rst_n is low, and in the cycle after its release before any edge has sampled candidates, disp_en, disp_unit0, disp_unit1 and q_shift are all zero.
- R2: Slot 0 dispatches when all of the following hold: it is valid; its unit code is below NUM_UNITS; that unit is not busy or has its reservation station free; if q_wr[0] is set, ren_free is at least 1; cq_free is at least 1; and the serialize rule (R7) allows it.
- R3: Dispatch is in order. disp_en[1] is never set unless disp_en[0] is set in the same cycle, and an invalid slot 0 (q_vld[0]=0) blocks slot 1.
- R4: If both slots target the same unit, slot 1 dispatches only when that unit's bit in DUAL_MASK is set and the unit is both not busy and has its station free. Otherwise slot 1 needs its own unit to accept, as in R2.
- R5: The rename registers needed by the dispatched pair (q_wr[0] plus q_wr[1]) never exceed ren_free. With ren_free = 1 and two writers, only slot 0 goes.
- R6: Each dispatched instruction needs one completion-queue slot. cq_free = 0 blocks all dispatch, and cq_free = 1 allows at most one.
- R7: A slot-0 instruction with q_ser[0] set dispatches only when cq_free equals CQ_DEPTH (completion queue empty), and slot 1 never dispatches with it. A slot-1 instruction with q_ser[1] set never dispatches alongside slot 0.
- R8: q_shift equals the number of set bits of disp_en. disp_unitN carries slot N's unit code when disp_en[N] is set and is zero otherwise.
- R9: A unit code of NUM_UNITS or above is never accepted, so that slot does not dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_vld | input | 2 | Entry valid, bit 0 = oldest |
| q_unit0 | input | UW | Target unit code of slot 0 |
| q_unit1 | input | UW | Target unit code of slot 1 |
| q_wr | input | 2 | Slot writes a result and needs a rename register |
| q_ser | input | 2 | Slot is completion-serialized |
| unit_busy | input | NUM_UNITS | Unit cannot start a new instruction this cycle |
| unit_rs_free | input | NUM_UNITS | Unit's reservation station has room |
| ren_free | input | RW | Free rename registers |
| cq_free | input | CW | Free completion-queue slots (CQ_DEPTH = empty) |
| disp_en | output | 2 | Registered grant per slot |
| disp_unit0 | output | UW | Unit code granted to slot 0, zero if none |
| disp_unit1 | output | UW | Unit code granted to slot 1, zero if none |
| q_shift | output | 2 | Entries to remove from the queue head |

## Verification
The hardest case to reach from the ports is a pair for the one dual-accepting unit where exactly one of its two acceptance paths is open. The same case must also pass the rename, completion-queue and serialize gates. Uniform random input rarely lines all of these up. The stimulus therefore draws unit codes from a narrow range so that slots collide often, and it biases cq_free toward 0, 1 and full. Directed cases then pin the dual unit with busy set or station full. They also cover serialize under an empty and an almost-empty completion queue, and an out-of-range unit code.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int SLOTS = 2;

  typedef struct packed {
    logic vld;
    logic wr;
    logic ser;
  } dsc_cand_t;

  function automatic logic [1:0] grant_count(input logic [1:0] g);
    return {1'b0, g[0]} + {1'b0, g[1]};
  endfunction
endpackage

// File: rtl/dsc_unit_gate.sv
module dsc_unit_gate #(
  parameter int NUM_UNITS = 5,
  parameter logic [NUM_UNITS-1:0] DUAL_MASK = '0,
  localparam int UW = $clog2(NUM_UNITS),
  localparam int UPAD = 1 << UW
) (
  input  logic [UW-1:0]        unit0,
  input  logic [UW-1:0]        unit1,
  input  logic [NUM_UNITS-1:0] busy,
  input  logic [NUM_UNITS-1:0] rs_free,
  output logic                 ok0,
  output logic                 ok1_pair
);
  logic [UPAD-1:0] take_one;
  logic [UPAD-1:0] take_two;

  // One entry per code value; codes past the last unit accept nothing.
  for (genvar u = 0; u < UPAD; u++) begin : g_unit
    if (u < NUM_UNITS) begin : g_real
      assign take_one[u] = ~busy[u] | rs_free[u];
      if (DUAL_MASK[u]) begin : g_dual
        assign take_two[u] = ~busy[u] & rs_free[u];
      end else begin : g_single
        assign take_two[u] = 1'b0;
      end
    end else begin : g_void
      assign take_one[u] = 1'b0;
      assign take_two[u] = 1'b0;
    end
  end

  always_comb begin
    ok0      = take_one[unit0];
    ok1_pair = (unit0 == unit1) ? take_two[unit1] : take_one[unit1];
  end
endmodule

// File: rtl/dsc_res_gate.sv
module dsc_res_gate #(
  parameter int RW = 3,
  parameter int CW = 3,
  parameter int CQ_DEPTH = 6
) (
  input  dsc_pkg::dsc_cand_t c0,
  input  dsc_pkg::dsc_cand_t c1,
  input  logic [RW-1:0]      ren_free,
  input  logic [CW-1:0]      cq_free,
  output logic               res0_ok,
  output logic               res1_ok
);
  localparam logic [CW-1:0] CQ_FULL_FREE = CW'(CQ_DEPTH);

  logic [RW:0] ren_need_pair;
  logic        cq_empty;

  always_comb begin
    ren_need_pair = {{RW{1'b0}}, c0.wr} + {{RW{1'b0}}, c1.wr};
    cq_empty      = (cq_free == CQ_FULL_FREE);
    res0_ok = (!c0.wr || ren_free != '0)
            && (cq_free != '0)
            && (!c0.ser || cq_empty);
    // Slot 1 is judged assuming slot 0 also leaves this cycle.
    res1_ok = ({1'b0, ren_free} >= ren_need_pair)
            && (cq_free >= CW'(2))
            && !c0.ser && !c1.ser;
  end
endmodule

// File: rtl/dispatch_stall_ctrl.sv
module dispatch_stall_ctrl #(
  parameter int NUM_UNITS = 5,
  parameter int REN_DEPTH = 6,
  parameter int CQ_DEPTH  = 6,
  parameter logic [NUM_UNITS-1:0] DUAL_MASK = 5'b00100,
  localparam int UW = $clog2(NUM_UNITS),
  localparam int RW = $clog2(REN_DEPTH + 1),
  localparam int CW = $clog2(CQ_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           q_vld,
  input  logic [UW-1:0]        q_unit0,
  input  logic [UW-1:0]        q_unit1,
  input  logic [1:0]           q_wr,
  input  logic [1:0]           q_ser,
  input  logic [NUM_UNITS-1:0] unit_busy,
  input  logic [NUM_UNITS-1:0] unit_rs_free,
  input  logic [RW-1:0]        ren_free,
  input  logic [CW-1:0]        cq_free,
  output logic [1:0]           disp_en,
  output logic [UW-1:0]        disp_unit0,
  output logic [UW-1:0]        disp_unit1,
  output logic [1:0]           q_shift
);
  import dsc_pkg::*;

  dsc_cand_t c0, c1;
  logic unit_ok0, unit_ok1;
  logic res_ok0, res_ok1;
  logic [1:0] go;

  assign c0 = '{vld: q_vld[0], wr: q_wr[0], ser: q_ser[0]};
  assign c1 = '{vld: q_vld[1], wr: q_wr[1], ser: q_ser[1]};

  dsc_unit_gate #(.NUM_UNITS(NUM_UNITS), .DUAL_MASK(DUAL_MASK)) u_unit (
    .unit0(q_unit0), .unit1(q_unit1), .busy(unit_busy), .rs_free(unit_rs_free),
    .ok0(unit_ok0), .ok1_pair(unit_ok1)
  );

  dsc_res_gate #(.RW(RW), .CW(CW), .CQ_DEPTH(CQ_DEPTH)) u_res (
    .c0(c0), .c1(c1), .ren_free(ren_free), .cq_free(cq_free),
    .res0_ok(res_ok0), .res1_ok(res_ok1)
  );

  always_comb begin
    go[0] = c0.vld && unit_ok0 && res_ok0;
    go[1] = go[0] && c1.vld && unit_ok1 && res_ok1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_en    <= '0;
      disp_unit0 <= '0;
      disp_unit1 <= '0;
      q_shift    <= '0;
    end else begin
      disp_en    <= go;
      disp_unit0 <= go[0] ? q_unit0 : '0;
      disp_unit1 <= go[1] ? q_unit1 : '0;
      q_shift    <= grant_count(go);
    end
  end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int NUM_UNITS = 5,
  parameter int CQ_DEPTH  = 6,
  parameter logic [NUM_UNITS-1:0] DUAL_MASK = '0,
  parameter int UW = 3,
  parameter int RW = 3,
  parameter int CW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           q_vld,
  input logic [UW-1:0]        q_unit0,
  input logic [UW-1:0]        q_unit1,
  input logic [1:0]           q_wr,
  input logic [1:0]           q_ser,
  input logic [NUM_UNITS-1:0] unit_busy,
  input logic [NUM_UNITS-1:0] unit_rs_free,
  input logic [RW-1:0]        ren_free,
  input logic [CW-1:0]        cq_free,
  input logic [1:0]           disp_en,
  input logic [UW-1:0]        disp_unit0,
  input logic [UW-1:0]        disp_unit1,
  input logic [1:0]           q_shift
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en[1] |-> disp_en[0]);

  a_r3_head_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(q_vld[0]) |-> disp_en == 2'b00);

  a_r6_cq_full: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cq_free) == '0 |-> disp_en == 2'b00);

  a_r6_cq_one: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cq_free) == CW'(1) |-> !disp_en[1]);

  a_r5_no_rename: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(ren_free) == '0 && $past(q_wr[0]) |-> !disp_en[0]);

  a_r7_serial_alone: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && disp_en[0] && $past(q_ser[0])
      |-> !disp_en[1] && $past(cq_free) == CW'(CQ_DEPTH));

  a_r7_serial_young: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(q_ser[1]) |-> !disp_en[1]);

  a_r8_shift: assert property (@(posedge clk) disable iff (!rst_n)
    q_shift == 2'($countones(disp_en)));

  a_r8_idle_unit: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en[1] |-> disp_unit1 == '0);

  a_r4_same_unit: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && disp_en[1] && $past(q_unit0) == $past(q_unit1)
      |-> $past(q_unit0) < UW'(NUM_UNITS));

  a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en[0] |-> disp_unit0 < UW'(NUM_UNITS));
endmodule

bind dispatch_stall_ctrl dsc_checker #(
  .NUM_UNITS(NUM_UNITS), .CQ_DEPTH(CQ_DEPTH), .DUAL_MASK(DUAL_MASK),
  .UW(UW), .RW(RW), .CW(CW)
) u_chk (.*);

// File: tb/sim_dispatch_stall_ctrl.sv
`timescale 1ns/1ps
module sim_dispatch_stall_ctrl;
  localparam int NU = 5;
  localparam int CQD = 6;
  localparam int UW = 3;
  localparam int RW = 3;
  localparam int CW = 3;
  localparam int DUAL_UNIT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] q_vld = '0, q_wr = '0, q_ser = '0;
  logic [UW-1:0] q_unit0 = '0, q_unit1 = '0;
  logic [NU-1:0] unit_busy = '0, unit_rs_free = '0;
  logic [RW-1:0] ren_free = '0;
  logic [CW-1:0] cq_free = '0;
  logic [1:0] disp_en, q_shift;
  logic [UW-1:0] disp_unit0, disp_unit1;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dispatch_stall_ctrl u0 (.*);

  function automatic bit accepts(input logic [UW-1:0] u);
    if (u >= NU) return 1'b0;
    return !unit_busy[u] || unit_rs_free[u];
  endfunction

  // Expected bundle {disp_en, disp_unit0, disp_unit1, q_shift}
  function automatic logic [9:0] model();
    bit e0, e1, pair;
    int need;
    need = int'(q_wr[0]) + int'(q_wr[1]);
    e0 = q_vld[0] && accepts(q_unit0) && (!q_wr[0] || ren_free >= 1)
         && cq_free >= 1 && (!q_ser[0] || cq_free == CQD);
    if (q_unit0 == q_unit1)
      pair = (q_unit0 == DUAL_UNIT) && !unit_busy[DUAL_UNIT] && unit_rs_free[DUAL_UNIT];
    else
      pair = accepts(q_unit1);
    e1 = e0 && q_vld[1] && pair && int'(ren_free) >= need && cq_free >= 2
         && !q_ser[0] && !q_ser[1];
    return {e1, e0, e0 ? q_unit0 : 3'd0, e1 ? q_unit1 : 3'd0,
            2'(int'(e0) + int'(e1))};
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    logic [9:0] act;
    act = {disp_en, disp_unit0, disp_unit1, q_shift};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got en=%b u0=%0d u1=%0d sh=%0d expected en=%b u0=%0d u1=%0d sh=%0d",
               tag, act[9:8], act[7:5], act[4:2], act[1:0],
               exp[9:8], exp[7:5], exp[4:2], exp[1:0]);
    end
  endtask

  task automatic base();
    q_vld = 2'b11; q_wr = 2'b00; q_ser = 2'b00;
    q_unit0 = 3'd0; q_unit1 = 3'd1;
    unit_busy = '0; unit_rs_free = '0;
    ren_free = 3'd6; cq_free = 3'(CQD);
  endtask

  // Inputs are set at a falling edge; result is sampled at the next falling edge.
  task automatic step(input string tag);
    logic [9:0] exp;
    exp = model();
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if ({disp_en, disp_unit0, disp_unit1, q_shift} !== 10'd0) begin
      n_fail++;
      $display("FAIL R1: outputs in reset %b expected 0",
               {disp_en, disp_unit0, disp_unit1, q_shift});
    end
    base();
    rst_n = 1'b1;
    #1;
    n_run++;
    if (disp_en !== 2'b00) begin
      n_fail++;
      $display("FAIL R1: disp_en after release %b expected 00", disp_en);
    end
    @(negedge clk);

    base(); step("R8 two different idle units");
    check("R8 both granted", {2'b11, 3'd0, 3'd1, 2'd2});
    base(); unit_busy[0] = 1'b1; step("R3 head blocked by busy unit");
    base(); q_vld = 2'b10; step("R3 invalid head");
    base(); q_unit0 = 3'd3; q_unit1 = 3'd3; unit_rs_free[3] = 1'b1; step("R4 single unit twice");
    base(); q_unit0 = 3'd2; q_unit1 = 3'd2; unit_rs_free[2] = 1'b1; step("R4 dual unit idle and room");
    base(); q_unit0 = 3'd2; q_unit1 = 3'd2; unit_busy[2] = 1'b1; unit_rs_free[2] = 1'b1;
    step("R4 dual unit busy");
    base(); q_unit0 = 3'd2; q_unit1 = 3'd2; step("R4 dual unit no room");
    base(); q_unit0 = 3'd1; unit_busy[1] = 1'b1; unit_rs_free[1] = 1'b1; step("R2 station takes head");
    base(); q_wr = 2'b11; ren_free = 3'd1; step("R5 one rename for two writers");
    base(); q_wr = 2'b10; ren_free = 3'd0; step("R5 head no write, young writes");
    base(); q_wr = 2'b01; ren_free = 3'd0; step("R5 head writes no rename");
    base(); cq_free = 3'd0; step("R6 completion queue full");
    base(); cq_free = 3'd1; step("R6 one completion slot");
    base(); q_ser = 2'b01; step("R7 serialized head empty queue");
    base(); q_ser = 2'b01; cq_free = 3'(CQD - 1); step("R7 serialized head nonempty");
    base(); q_ser = 2'b10; step("R7 serialized young");
    base(); q_unit0 = 3'd6; step("R9 out of range head");
    base(); q_unit1 = 3'd7; step("R9 out of range young");
    base(); q_vld = 2'b01; q_unit0 = 3'd4; step("R8 single grant codes");

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      q_vld = 2'($urandom_range(3, 0));
      if ($urandom_range(3, 0) != 0) q_vld = 2'b11;
      q_unit0 = 3'($urandom_range(($urandom_range(7, 0) == 0) ? 7 : 3, 0));
      q_unit1 = 3'($urandom_range(($urandom_range(7, 0) == 0) ? 7 : 3, 0));
      q_wr = 2'($urandom_range(3, 0));
      q_ser = ($urandom_range(7, 0) == 0) ? 2'($urandom_range(3, 1)) : 2'b00;
      unit_busy = NU'($urandom);
      unit_rs_free = NU'($urandom);
      ren_free = 3'($urandom_range(3, 0));
      r = $urandom_range(5, 0);
      cq_free = (r == 0) ? 3'd0 : (r == 1) ? 3'd1 : (r == 2) ? 3'(CQD)
                : 3'($urandom_range(CQD, 0));
      step("R2 random mix");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule